// File: doc/BRIEF.md
# Frame-Synchronous Transmit Scrambler

This block randomises a byte-serial SONET/SDH transmit stream before line coding. It keeps a 7-stage pseudo-random generator built on x^7 + x^6 + 1, which repeats every 127 bits. Each data byte is XORed with eight successive generator bits, and the most significant bit is handled first. The stream arrives one byte per clock, qualified by a valid strobe. Each byte carries its row and column number within the frame, so the block needs no framing logic of its own.

The whole transport-overhead portion of the first row is sent in clear, and the generator does not step during those bytes. That portion holds the framing bytes, the trace byte and the two spare bytes behind it. The generator is reloaded with all ones at the first byte that follows that portion, which ties the sequence to the frame. A test control turns off the XOR so that data passes through unmodified, while the generator keeps its frame alignment. The output is registered with one cycle of latency, and its valid strobe and position markers are delayed to match. A parity generator placed downstream can therefore tap the scrambled bytes directly.

Top module: `fss_tx_scrambler`

## Requirements
- R1: Each scrambled byte equals the input byte XOR eight generator bits. The first bit produced goes to output bit 7. Per bit step the generator emits its oldest stage s[6] and shifts in s[6] XOR s[5].
- R2: A byte at row 0 and column below OH_COLS (the first-row overhead) leaves the block equal to its input byte.
- R3: At row 0, column OH_COLS, the generator is taken as all ones. With zero data the byte there comes out as 8'hFE, and the next valid byte as 8'h04.
- R4: With scr_en at 0 every output byte equals its input byte. The generator still steps for each byte outside the first-row overhead, so restoring scr_en resumes the aligned sequence.
- R5: out_valid, out_row and out_col repeat in_valid, in_row and in_col one clock later. out_data belongs to the byte that was accepted one clock earlier.
- R6: The generator holds its state across cycles with in_valid low and across first-row overhead bytes. The byte that follows such a cycle uses the next unused generator bits.
- R7: While rst_n is low, out_valid and out_data are 0. The generator is set to all ones.
- R8: Bytes in rows other than 0, including their overhead columns, are scrambled with the sequence continuing from the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_en | input | 1 | 1 applies scrambling; 0 passes data through |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_row | input | ROW_W | Row index of the input byte, 0 = first row |
| in_col | input | COL_W | Column index of the input byte, 0 = first column |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Scrambled byte |
| out_row | output | ROW_W | Row index matching out_data |
| out_col | output | COL_W | Column index matching out_data |

## Verification
A wrong generator state does not stay hidden. From the next scrambled byte onward, every byte is XORed with the wrong bits, until the frame's reload point restores alignment. A single misplaced step therefore corrupts up to a full frame of payload at the ports, and the first bad byte appears one clock after the faulty input. A wrong overhead or reload decode shows up at once as a first-row byte that comes out altered, or as a byte at the reload column other than FE when the data is zero.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int unsigned GEN_STAGES = 7;
  localparam int unsigned BYTE_W     = 8;
  typedef logic [GEN_STAGES-1:0] gen_state_t;
  typedef logic [BYTE_W-1:0]     byte_t;
  localparam gen_state_t GEN_SEED = '1;
endpackage

// File: rtl/fss_pos_decode.sv
module fss_pos_decode #(
  parameter int unsigned ROW_W   = 4,
  parameter int unsigned COL_W   = 9,
  parameter int unsigned OH_COLS = 9
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             first_row_oh,
  output logic             reload_pt
);
  localparam logic [COL_W-1:0] OH_END = COL_W'(OH_COLS);

  logic top_row;

  always_comb begin
    top_row      = (row == '0);
    first_row_oh = top_row && (col < OH_END);
    reload_pt    = top_row && (col == OH_END);
  end
endmodule

// File: rtl/fss_keystream.sv
module fss_keystream
  import fss_pkg::*;
(
  input  gen_state_t cur_state,
  input  logic       reload,
  output byte_t      key_byte,
  output gen_state_t nxt_state
);
  gen_state_t chain [0:BYTE_W];

  assign chain[0] = reload ? GEN_SEED : cur_state;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_step
    assign key_byte[BYTE_W-1-b] = chain[b][GEN_STAGES-1];
    assign chain[b+1] = {chain[b][GEN_STAGES-2:0],
                         chain[b][GEN_STAGES-1] ^ chain[b][GEN_STAGES-2]};
  end

  assign nxt_state = chain[BYTE_W];
endmodule

// File: rtl/fss_tx_scrambler.sv
module fss_tx_scrambler
  import fss_pkg::*;
#(
  parameter int unsigned ROW_W   = 4,
  parameter int unsigned COL_W   = 9,
  parameter int unsigned OH_COLS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scr_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col
);
  localparam logic [COL_W-1:0] OH_END = COL_W'(OH_COLS);

  logic       first_row_oh;
  logic       reload_pt;
  gen_state_t gen_q, gen_d, gen_step;
  byte_t      key_byte;
  logic       gen_ce;
  byte_t      data_d;

  fss_pos_decode #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .OH_COLS (OH_COLS)
  ) pos_i (
    .row          (in_row),
    .col          (in_col),
    .first_row_oh (first_row_oh),
    .reload_pt    (reload_pt)
  );

  fss_keystream ks_i (
    .cur_state (gen_q),
    .reload    (reload_pt),
    .key_byte  (key_byte),
    .nxt_state (gen_step)
  );

  always_comb begin
    gen_ce = in_valid && !first_row_oh;
    gen_d  = gen_step;
    if (gen_ce && scr_en) data_d = in_data ^ key_byte;
    else                  data_d = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= GEN_SEED;
    else if (gen_ce) gen_q <= gen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_row  <= '0;
      out_col  <= '0;
    end else if (in_valid) begin
      out_data <= data_d;
      out_row  <= in_row;
      out_col  <= in_col;
    end
  end

  // R2: first-row overhead leaves unchanged
  a_r2_oh_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row == '0 && in_col < OH_END) |=> (out_data == $past(in_data)));

  // R3: reload point with scrambling on yields data XOR FE
  a_r3_reload_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scr_en && in_row == '0 && in_col == OH_END)
      |=> (out_data == ($past(in_data) ^ 8'hFE)));

  // R4: scrambling off passes data through
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scr_en) |=> (out_data == $past(in_data)));

  // R5: strobe and markers delayed one clock
  a_r5_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
  a_r5_pos_lat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_row == $past(in_row) && out_col == $past(in_col)));

  // R6: generator frozen on idle and first-row overhead
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || (in_row == '0 && in_col < OH_END)) |=> $stable(gen_q));

  // R1: generator never locks in the all-zero state
  a_r1_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != '0);
endmodule

// File: tb/fss_tx_scrambler_tb.sv
module fss_tx_scrambler_tb_top;
  localparam int ROW_W   = 4;
  localparam int COL_W   = 9;
  localparam int OH_COLS = 9;
  localparam int NCOLS   = 24;
  localparam int NROWS   = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             scr_en;
  logic             in_valid;
  logic [7:0]       in_data;
  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  logic             out_valid;
  logic [7:0]       out_data;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [6:0] m_state;
  logic       e_valid;
  logic [7:0] e_data;
  logic [ROW_W-1:0] e_row;
  logic [COL_W-1:0] e_col;
  string      e_tag;

  always #4 clk = ~clk;

  fss_tx_scrambler #(.ROW_W(ROW_W), .COL_W(COL_W), .OH_COLS(OH_COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .in_valid(in_valid),
    .in_data(in_data), .in_row(in_row), .in_col(in_col),
    .out_valid(out_valid), .out_data(out_data), .out_row(out_row), .out_col(out_col));

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] key_of(inout logic [6:0] s);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) begin
      k[7-i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return k;
  endfunction

  // compare previous expectation, then drive one cycle
  task automatic drive(input logic v, input logic [7:0] d, input int r, input int c,
                       input logic en, input string tag_override);
    logic [7:0] k;
    check("R5 valid", out_valid, e_valid);
    if (e_valid) begin
      check({e_tag, " data"}, out_data, e_data);
      check("R5 position", {out_row, out_col}, {e_row, e_col});
    end
    in_valid = v; in_data = d; in_row = ROW_W'(r); in_col = COL_W'(c); scr_en = en;
    e_valid = v;
    if (v) begin
      e_row = ROW_W'(r); e_col = COL_W'(c);
      if (r == 0 && c < OH_COLS) begin
        e_data = d; e_tag = "R2";
      end else begin
        if (r == 0 && c == OH_COLS) m_state = 7'h7F;
        k = key_of(m_state);
        e_data = en ? (d ^ k) : d;
        e_tag = !en ? "R4" : (r == 0 && c == OH_COLS) ? "R3" : (r != 0) ? "R8" : "R1";
      end
      if (tag_override != "") e_tag = tag_override;
    end
    @(negedge clk);
  endtask

  task automatic run_frame(input logic en, input int gap_pct, input bit zero_data);
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < NCOLS; c++) begin
        bit gapped = 0;
        while (($urandom % 100) < gap_pct) begin
          drive(1'b0, 8'h00, 0, 0, en, "");
          gapped = 1;
        end
        drive(1'b1, zero_data ? 8'h00 : 8'($urandom), r, c, en, gapped ? "R6" : "");
      end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; scr_en = 1'b1; in_valid = 1'b0; in_data = '0; in_row = '0; in_col = '0;
    m_state = 7'h7F; e_valid = 1'b0; e_data = '0; e_row = '0; e_col = '0; e_tag = "R1";
    repeat (3) @(negedge clk);
    check("R7 reset valid", out_valid, 0);
    check("R7 reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: zero data at reload point gives FE then 04
    for (int c = 0; c <= OH_COLS + 1; c++) drive(1'b1, 8'h00, 0, c, 1'b1, "");
    drive(1'b0, 8'h00, 0, 0, 1'b1, "");
    check("R3 first byte", e_data, 8'h04);
    run_frame(1'b1, 0, 1'b1);
    run_frame(1'b1, 20, 1'b0);
    run_frame(1'b0, 10, 1'b0);
    run_frame(1'b1, 30, 1'b0);
    for (int f = 0; f < 3; f++) run_frame(1'b1, 5, 1'b0);
    drive(1'b0, 8'h00, 0, 0, 1'b1, "");
    drive(1'b0, 8'h00, 0, 0, 1'b1, "");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule